// File: doc/BRIEF.md
# Load-Use Stall Interlock

This block is the hazard detector and hold controller for a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). Every cycle it takes the two source register numbers of the instruction sitting in decode, each with a flag saying whether the instruction really reads it. It compares them with the destination register numbers and kind flags of the two older instructions in execute and memory. From that comparison it produces three controls: an enable for the program counter, an enable for the fetch/decode latch, and a request to load a bubble (a nop) into the decode/execute latch.

Operands are read in decode and written back in the last stage, so only read-after-write conflicts exist. With the forwarding network present (the default build), the only conflict that cannot be bypassed is a load in execute whose value is needed by the very next instruction. The load's data appears only at the end of the memory stage, so one stall cycle is unavoidable. A build without forwarding stalls on any register-writing instruction in execute or memory. Register number zero never produces a dependence. A squash from branch resolution overrides a stall.

The outputs are combinational in the decode-stage fields, because the hold must act in the same cycle as the hazard.

Top module: `load_use_interlock`

## Requirements
- R1: When execute holds a load (`ex_load`=1) whose `ex_dst` equals a used decode source, the block stalls: `pc_en`=0, `ifid_en`=0, `idex_bubble`=1.
- R2: Both decode sources (`id_rs`, `id_rt`) are compared. A source whose use flag is 0 never causes a stall, even if its number matches.
- R3: A destination of register 0 never matches any source, so it never causes a stall in either build.
- R4: With forwarding (`FWD_EN`=1), a non-load writer in execute and any instruction in memory, load or not, never cause a stall.
- R5: Without forwarding (`FWD_EN`=0), a stall occurs when a used source matches `ex_dst` of a writer (`ex_wr` or `ex_load`) or `me_dst` of a writer (`me_wr`=1). A matching number with its write flag low does not stall.
- R6: `squash`=1 outside reset gives `pc_en`=1, `ifid_en`=1, `idex_bubble`=1, whatever the hazard inputs are.
- R7: With no hazard and no squash, the block gives `pc_en`=1, `ifid_en`=1, `idex_bubble`=0.
- R8: While `rst`=1 the block gives `pc_en`=0, `ifid_en`=0, `idex_bubble`=1.
- R9: The two enables are always equal, and whenever they are 0 `idex_bubble` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst | input | 1 | Synchronous active-high reset of the pipeline |
| id_rs | input | REG_W | First source register number of the decode instruction |
| id_rs_use | input | 1 | Decode instruction reads `id_rs` |
| id_rt | input | REG_W | Second source register number of the decode instruction |
| id_rt_use | input | 1 | Decode instruction reads `id_rt` |
| ex_dst | input | REG_W | Destination register number of the execute instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| me_dst | input | REG_W | Destination register number of the memory-stage instruction |
| me_wr | input | 1 | Memory-stage instruction writes a register |
| squash | input | 1 | Decode instruction is being cancelled by a resolved branch |
| pc_en | output | 1 | Program counter may advance |
| ifid_en | output | 1 | Fetch/decode latch may capture |
| idex_bubble | output | 1 | Load a nop into the decode/execute latch |

## Verification
A load-use stall request and a squash can arrive in the same cycle. The bench provokes this by holding a load in execute whose destination matches a used decode source while it raises `squash`. For that cycle it expects the enables released together with the bubble still inserted, and it checks the next cycle with the squash removed. The same collision is driven into the non-forwarding build, where it is caused by a memory-stage writer, so that both hazard paths are checked against the override.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  // number of register sources carried by a decoded instruction
  localparam int NUM_SRC = 2;

  // reason the hold controller chose its outputs this cycle
  typedef enum logic [1:0] {
    HOLD_NONE   = 2'd0,
    HOLD_HAZARD = 2'd1,
    HOLD_RESET  = 2'd2
  } hold_e;

  // front-end pipeline control bundle
  typedef struct packed {
    logic pc_en;
    logic ifid_en;
    logic bubble;
  } front_ctrl_t;

endpackage

// File: rtl/ilk_src_cmp.sv
// Single source-versus-producer comparator. Register zero is never a match.
module ilk_src_cmp #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             src_use,
  input  logic [REG_W-1:0] dst,
  input  logic             dst_wr,
  output logic             hit
);

  logic dst_nonzero;
  logic same_reg;

  always_comb begin
    dst_nonzero = |dst;
    same_reg    = (src == dst);
    hit         = src_use && dst_wr && dst_nonzero && same_reg;
  end

endmodule

// File: rtl/ilk_stage_scan.sv
// Compares all decode sources against one producing stage.
module ilk_stage_scan #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC-1:0][REG_W-1:0] srcs,
  input  logic [NSRC-1:0]            uses,
  input  logic [REG_W-1:0]           dst,
  input  logic                       dst_wr,
  output logic                       any_hit
);

  logic [NSRC-1:0] hits;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    ilk_src_cmp #(.REG_W(REG_W)) u_cmp (
      .src     (srcs[g]),
      .src_use (uses[g]),
      .dst     (dst),
      .dst_wr  (dst_wr),
      .hit     (hits[g])
    );
  end

  assign any_hit = |hits;

endmodule

// File: rtl/ilk_hold_ctrl.sv
// Turns the hazard decision, squash and reset into front-end controls.
module ilk_hold_ctrl
  import ilk_pkg::*;
(
  input  logic        rst,
  input  logic        squash,
  input  logic        hazard,
  output front_ctrl_t ctrl
);

  hold_e mode;

  always_comb begin
    if (rst)                    mode = HOLD_RESET;
    else if (hazard && !squash) mode = HOLD_HAZARD;
    else                        mode = HOLD_NONE;
  end

  always_comb begin
    unique case (mode)
      HOLD_RESET:  ctrl = '{pc_en: 1'b0, ifid_en: 1'b0, bubble: 1'b1};
      HOLD_HAZARD: ctrl = '{pc_en: 1'b0, ifid_en: 1'b0, bubble: 1'b1};
      default:     ctrl = '{pc_en: 1'b1, ifid_en: 1'b1, bubble: squash};
    endcase
  end

endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
  import ilk_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int FWD_EN = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] id_rs,
  input  logic             id_rs_use,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_rt_use,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic             ex_load,
  input  logic [REG_W-1:0] me_dst,
  input  logic             me_wr,
  input  logic             squash,
  output logic             pc_en,
  output logic             ifid_en,
  output logic             idex_bubble
);

  localparam bit HAS_FWD = (FWD_EN != 0);

  logic [NUM_SRC-1:0][REG_W-1:0] id_srcs;
  logic [NUM_SRC-1:0]            id_uses;
  logic                          ex_produces;
  logic                          me_produces;
  logic                          ex_hit;
  logic                          me_hit;
  logic                          hazard;
  front_ctrl_t                   ctrl;

  assign id_srcs = {id_rt, id_rs};
  assign id_uses = {id_rt_use, id_rs_use};

  // With bypassing only a load in execute is late; without it every writer is.
  assign ex_produces = HAS_FWD ? ex_load : (ex_wr | ex_load);
  assign me_produces = HAS_FWD ? 1'b0    : me_wr;

  ilk_stage_scan #(.REG_W(REG_W), .NSRC(NUM_SRC)) u_scan_ex (
    .srcs    (id_srcs),
    .uses    (id_uses),
    .dst     (ex_dst),
    .dst_wr  (ex_produces),
    .any_hit (ex_hit)
  );

  ilk_stage_scan #(.REG_W(REG_W), .NSRC(NUM_SRC)) u_scan_me (
    .srcs    (id_srcs),
    .uses    (id_uses),
    .dst     (me_dst),
    .dst_wr  (me_produces),
    .any_hit (me_hit)
  );

  assign hazard = ex_hit | me_hit;

  ilk_hold_ctrl u_hold (
    .rst    (rst),
    .squash (squash),
    .hazard (hazard),
    .ctrl   (ctrl)
  );

  assign pc_en       = ctrl.pc_en;
  assign ifid_en     = ctrl.ifid_en;
  assign idex_bubble = ctrl.bubble;

  // R1: load in execute feeding a used decode source holds the front end
  a_r1_load_use_holds: assert property (@(posedge clk) disable iff (rst)
    (ex_load && (ex_dst != '0) && !squash &&
     ((id_rs_use && id_rs == ex_dst) || (id_rt_use && id_rt == ex_dst)))
    |-> (!pc_en && !ifid_en && idex_bubble));

  // R3: no producer with a nonzero destination means no hold
  a_r3_zero_dst_free: assert property (@(posedge clk) disable iff (rst)
    ((ex_dst == '0) && (me_dst == '0)) |-> pc_en);

  // R4: with bypassing, no load in execute means no hold
  a_r4_fwd_no_stall: assert property (@(posedge clk) disable iff (rst)
    (HAS_FWD && !ex_load) |-> (pc_en && ifid_en));

  // R6: squash releases the hold and still inserts a bubble
  a_r6_squash_wins: assert property (@(posedge clk) disable iff (rst)
    squash |-> (pc_en && ifid_en && idex_bubble));

  // R9: enables move together and a hold always carries a bubble
  a_r9_enables_paired: assert property (@(posedge clk) disable iff (rst)
    (pc_en == ifid_en) && (!pc_en -> idex_bubble));

endmodule

// File: tb/load_use_interlock_bench.sv
module load_use_interlock_bench;

  localparam int RW = 5;

  typedef struct {
    logic          rst;
    logic [RW-1:0] rs;
    logic          rs_use;
    logic [RW-1:0] rt;
    logic          rt_use;
    logic [RW-1:0] exd;
    logic          exw;
    logic          exl;
    logic [RW-1:0] med;
    logic          mew;
    logic          sq;
  } stim_t;

  typedef struct {
    logic [2:0] fwd;     // {pc_en, ifid_en, bubble}
    logic [2:0] nofwd;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  stim_t s;
  exp_t  q[$];
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  logic pc_a, ifid_a, bub_a;
  logic pc_b, ifid_b, bub_b;

  load_use_interlock #(.REG_W(RW), .FWD_EN(1)) u_load_use_interlock (
    .clk(clk), .rst(s.rst), .id_rs(s.rs), .id_rs_use(s.rs_use),
    .id_rt(s.rt), .id_rt_use(s.rt_use), .ex_dst(s.exd), .ex_wr(s.exw),
    .ex_load(s.exl), .me_dst(s.med), .me_wr(s.mew), .squash(s.sq),
    .pc_en(pc_a), .ifid_en(ifid_a), .idex_bubble(bub_a));

  load_use_interlock #(.REG_W(RW), .FWD_EN(0)) u_nofwd (
    .clk(clk), .rst(s.rst), .id_rs(s.rs), .id_rs_use(s.rs_use),
    .id_rt(s.rt), .id_rt_use(s.rt_use), .ex_dst(s.exd), .ex_wr(s.exw),
    .ex_load(s.exl), .me_dst(s.med), .me_wr(s.mew), .squash(s.sq),
    .pc_en(pc_b), .ifid_en(ifid_b), .idex_bubble(bub_b));

  // reference model written from the requirements
  function automatic logic [2:0] model(bit fwd, stim_t t);
    logic haz;
    if (t.rst) return 3'b001;                            // R8
    if (t.sq)  return 3'b111;                            // R6
    haz = 1'b0;
    for (int i = 0; i < 2; i++) begin
      logic [RW-1:0] src;
      logic          u;
      src = (i == 0) ? t.rs : t.rt;
      u   = (i == 0) ? t.rs_use : t.rt_use;
      if (u && src != 0) begin                           // R2, R3
        if (fwd) haz |= t.exl && (src == t.exd);         // R1, R4
        else     haz |= ((t.exw || t.exl) && src == t.exd) ||
                        (t.mew && src == t.med);         // R5
      end
    end
    return haz ? 3'b001 : 3'b110;                        // R1, R7
  endfunction

  task automatic step(stim_t t, string tag);
    exp_t e;
    @(posedge clk);
    #1;
    s = t;
    e.fwd   = model(1'b1, t);
    e.nofwd = model(1'b0, t);
    e.tag   = tag;
    q.push_back(e);
  endtask

  function automatic stim_t idle();
    stim_t t;
    t.rst = 1'b0; t.rs = '0; t.rs_use = 1'b0; t.rt = '0; t.rt_use = 1'b0;
    t.exd = '0; t.exw = 1'b0; t.exl = 1'b0; t.med = '0; t.mew = 1'b0;
    t.sq = 1'b0;
    return t;
  endfunction

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({pc_a, ifid_a, bub_a} !== e.fwd) begin
        failures++;
        $display("FAIL %s fwd build: got %b expected %b", e.tag,
                 {pc_a, ifid_a, bub_a}, e.fwd);
      end
      checks++;
      if ({pc_b, ifid_b, bub_b} !== e.nofwd) begin
        failures++;
        $display("FAIL %s nofwd build: got %b expected %b", e.tag,
                 {pc_b, ifid_b, bub_b}, e.nofwd);
      end
    end
  end

  initial begin
    stim_t t;
    s = idle();
    s.rst = 1'b1;
    t = idle(); t.rst = 1'b1; t.exl = 1'b1; t.exd = 5'd4;
    t.rs = 5'd4; t.rs_use = 1'b1;
    step(t, "R8 reset");
    step(t, "R8 reset held");

    t = idle(); step(t, "R7 idle");
    t = idle(); t.rs = 5'd2; t.rs_use = 1'b1; t.rt = 5'd3; t.rt_use = 1'b1;
    t.exd = 5'd9; t.exw = 1'b1; t.med = 5'd10; t.mew = 1'b1;
    step(t, "R7 independent stream");

    // load r5 then dependent op on rs
    t = idle(); t.rs = 5'd5; t.rs_use = 1'b1; t.exd = 5'd5; t.exw = 1'b1; t.exl = 1'b1;
    step(t, "R1 load-use rs");
    // next cycle: bubble in execute, load in memory
    t = idle(); t.rs = 5'd5; t.rs_use = 1'b1; t.med = 5'd5; t.mew = 1'b1;
    step(t, "R4 load in memory forwarded / R5 stall");

    // rt used vs unused
    t = idle(); t.rt = 5'd7; t.rt_use = 1'b1; t.exd = 5'd7; t.exw = 1'b1; t.exl = 1'b1;
    step(t, "R2 load-use rt");
    t.rt_use = 1'b0;
    step(t, "R2 rt not used");
    t = idle(); t.rs = 5'd7; t.rs_use = 1'b0; t.rt = 5'd7; t.rt_use = 1'b0;
    t.exd = 5'd7; t.exw = 1'b1; t.exl = 1'b1;
    step(t, "R2 neither used");

    // independent load
    t = idle(); t.rs = 5'd4; t.rs_use = 1'b1; t.rt = 5'd6; t.rt_use = 1'b1;
    t.exd = 5'd3; t.exw = 1'b1; t.exl = 1'b1;
    step(t, "R7 load independent");

    // load to r0 then use of r0
    t = idle(); t.rs = 5'd0; t.rs_use = 1'b1; t.rt = 5'd0; t.rt_use = 1'b1;
    t.exd = 5'd0; t.exw = 1'b1; t.exl = 1'b1; t.med = 5'd0; t.mew = 1'b1;
    step(t, "R3 r0 never matches");

    // ALU writer in execute
    t = idle(); t.rs = 5'd9; t.rs_use = 1'b1; t.exd = 5'd9; t.exw = 1'b1;
    step(t, "R4 alu in execute / R5 stall");
    t.exw = 1'b0;
    step(t, "R5 matching dst without write");
    t = idle(); t.rt = 5'd12; t.rt_use = 1'b1; t.med = 5'd12; t.mew = 1'b0;
    step(t, "R5 memory dst without write");
    t.mew = 1'b1;
    step(t, "R5 memory writer rt");

    // squash collides with stall requests
    t = idle(); t.rs = 5'd5; t.rs_use = 1'b1; t.exd = 5'd5; t.exw = 1'b1;
    t.exl = 1'b1; t.sq = 1'b1;
    step(t, "R6 squash over load-use");
    t.sq = 1'b0;
    step(t, "R1 after squash released");
    t = idle(); t.rt = 5'd11; t.rt_use = 1'b1; t.med = 5'd11; t.mew = 1'b1; t.sq = 1'b1;
    step(t, "R6 squash over memory writer");
    t = idle(); t.sq = 1'b1;
    step(t, "R6 squash alone");

    // max register number, both sources hit
    t = idle(); t.rs = 5'd31; t.rs_use = 1'b1; t.rt = 5'd31; t.rt_use = 1'b1;
    t.exd = 5'd31; t.exl = 1'b1;
    step(t, "R1 r31 both sources");
    t = idle(); step(t, "R7 back to idle");

    t = idle(); t.rst = 1'b1; step(t, "R8 reset again");

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule